// File: doc/BRIEF.md
# Compact Floating-Point Rounding Unit

This block takes a short floating-point value that an upstream arithmetic stage has produced with three extra low-order bits, and returns a correctly rounded 12-bit word. The packing is one sign bit, a five-bit exponent with bias 15 and a six-bit fraction behind an implied leading one. For example, the word with sign 1, exponent 10010 and fraction 100010 stands for -1.100010 x 2^3, which is -12.25. Rounding is to the nearest value, and an exact halfway case goes to the neighbour whose fraction LSB is zero.

The extended fraction at the input holds the six kept bits first and then a guard, a round and a sticky bit. When the increment carries out of the fraction, the significand is renormalized and the exponent goes up by one. An exponent that ends at all ones is not a finite value in this format. The block then saturates to the largest finite magnitude of the same sign and raises a flag. One result is accepted per cycle, and each result appears one cycle after its input.

Top module: `fpRound`

## Requirements
- R1: The result word is {sign, exponent[4:0], fraction[5:0]} (sign at bit 11, exponent at bits 10:6, fraction at bits 5:0). The extended input fraction is {fraction[5:0], guard, round, sticky}, with the guard at bit 2, the round at bit 1 and the sticky at bit 0.
- R2: When the guard bit is 0, the fraction and exponent pass through unchanged, whatever the round and sticky bits are.
- R3: When the guard bit is 1 and round or sticky is 1, the fraction is increased by one unit in the last place.
- R4: When the extra bits are exactly 100, the fraction is increased only if its LSB is 1, so the rounded LSB is 0 unless saturation applies.
- R5: When rounding carries out of a fraction of all ones, the result fraction is 000000 and the exponent is one higher.
- R6: When the final exponent would be 11111 (either from the input or from a carry), the overflow flag is 1 and the word is {sign, 11110, 111111}. In every other case the flag is 0.
- R7: The sign of the result equals the input sign.
- R8: A result appears one clock after its input is presented with the valid input high. The output valid is the input valid delayed by one cycle, and back-to-back inputs give back-to-back results.
- R9: During reset, output valid, word and overflow flag are all 0.
- R10: While the input valid is low, the output word and overflow flag keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input operand present |
| inSign | input | 1 | Sign of the operand |
| inExp | input | 5 | Biased exponent (bias 15) |
| inFracExt | input | 9 | Kept fraction, then guard, round and sticky bits |
| outValid | output | 1 | Result present |
| outWord | output | 12 | Rounded packed result |
| outOverflow | output | 1 | Exponent overflow, result saturated |

## Verification
The bench builds the block with its default widths: a five-bit exponent and a six-bit fraction. With these widths, a fraction of all ones and the exponents 11110 and 11111 are each reached by a single vector. As a result, the carry-out renormalization, the carry that pushes the exponent into saturation, and an input exponent that is already all ones are each exercised directly. With these short fields, every combination of the three extra bits can be hit at both fraction LSB values in a handful of vectors.

// File: rtl/fpRndPkg.sv
package fpRndPkg;

  // Strobes from the rounding decision logic to the datapath
  typedef struct packed {
    logic roundUp;   // add one unit in the last place
    logic renorm;    // increment carries out of the fraction
    logic saturate;  // final exponent is not finite
  } rndStrobes_t;

endpackage

// File: rtl/fpRndCtrl.sv
module fpRndCtrl
  import fpRndPkg::*;
#(
  parameter int EXP_W = 5
) (
  input  logic             fracLsb,
  input  logic             fracAllOnes,
  input  logic             guardBit,
  input  logic             roundBit,
  input  logic             stickyBit,
  input  logic [EXP_W-1:0] expIn,
  output rndStrobes_t      strobes
);

  localparam logic [EXP_W-1:0] EXP_MAX  = '1;
  localparam logic [EXP_W-1:0] EXP_EDGE = EXP_MAX - 1'b1;

  logic aboveHalf;
  logic exactHalf;
  logic upNow;
  logic carryNow;

  always_comb begin
    aboveHalf = guardBit & (roundBit | stickyBit);
    exactHalf = guardBit & ~roundBit & ~stickyBit;
    upNow     = aboveHalf | (exactHalf & fracLsb);
    carryNow  = upNow & fracAllOnes;
    strobes.roundUp  = upNow;
    strobes.renorm   = carryNow;
    strobes.saturate = (expIn == EXP_MAX) | (carryNow & (expIn == EXP_EDGE));
  end

endmodule

// File: rtl/fpRndPath.sv
module fpRndPath
  import fpRndPkg::*;
#(
  parameter int EXP_W  = 5,
  parameter int FRAC_W = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      inValid,
  input  logic                      inSign,
  input  logic [EXP_W-1:0]          inExp,
  input  logic [FRAC_W-1:0]         inFrac,
  input  rndStrobes_t               strobes,
  output logic                      outValid,
  output logic [EXP_W+FRAC_W:0]     outWord,
  output logic                      outOverflow
);

  localparam int SIG_W = FRAC_W + 2;
  localparam int WORD_W = EXP_W + FRAC_W + 1;
  localparam logic [EXP_W-1:0] SAT_EXP = {{(EXP_W-1){1'b1}}, 1'b0};

  logic [SIG_W-1:0]  sigSum;
  logic [FRAC_W-1:0] fracRes;
  logic [EXP_W-1:0]  expRes;
  logic [WORD_W-1:0] wordNext;

  always_comb begin
    // significand with implied one, plus optional ulp
    sigSum = {1'b0, 1'b1, inFrac} + {{(SIG_W-1){1'b0}}, strobes.roundUp};
    if (strobes.renorm) begin
      fracRes = sigSum[FRAC_W:1];
      expRes  = inExp + 1'b1;
    end else begin
      fracRes = sigSum[FRAC_W-1:0];
      expRes  = inExp;
    end
    if (strobes.saturate) begin
      wordNext = {inSign, SAT_EXP, {FRAC_W{1'b1}}};
    end else begin
      wordNext = {inSign, expRes, fracRes};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid    <= 1'b0;
      outWord     <= '0;
      outOverflow <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        outWord     <= wordNext;
        outOverflow <= strobes.saturate;
      end
    end
  end

endmodule

// File: rtl/fpRound.sv
module fpRound
  import fpRndPkg::*;
#(
  parameter int EXP_W  = 5,
  parameter int FRAC_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  inValid,
  input  logic                  inSign,
  input  logic [EXP_W-1:0]      inExp,
  input  logic [FRAC_W+2:0]     inFracExt,
  output logic                  outValid,
  output logic [EXP_W+FRAC_W:0] outWord,
  output logic                  outOverflow
);

  rndStrobes_t strobes;
  logic [FRAC_W-1:0] keptFrac;

  assign keptFrac = inFracExt[FRAC_W+2:3];

  fpRndCtrl #(.EXP_W(EXP_W)) u_ctrl (
    .fracLsb     (keptFrac[0]),
    .fracAllOnes (&keptFrac),
    .guardBit    (inFracExt[2]),
    .roundBit    (inFracExt[1]),
    .stickyBit   (inFracExt[0]),
    .expIn       (inExp),
    .strobes     (strobes)
  );

  fpRndPath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_path (
    .clk         (clk),
    .rst_n       (rst_n),
    .inValid     (inValid),
    .inSign      (inSign),
    .inExp       (inExp),
    .inFrac      (keptFrac),
    .strobes     (strobes),
    .outValid    (outValid),
    .outWord     (outWord),
    .outOverflow (outOverflow)
  );

endmodule

// File: rtl/fpRoundChk.sv
module fpRoundChk #(
  parameter int EXP_W  = 5,
  parameter int FRAC_W = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  inValid,
  input logic                  inSign,
  input logic [EXP_W-1:0]      inExp,
  input logic [FRAC_W+2:0]     inFracExt,
  input logic                  outValid,
  input logic [EXP_W+FRAC_W:0] outWord,
  input logic                  outOverflow
);

  localparam int TOP = EXP_W + FRAC_W;
  localparam logic [EXP_W-1:0] EXP_MAX = '1;
  localparam logic [EXP_W-1:0] SAT_EXP = {{(EXP_W-1){1'b1}}, 1'b0};

  p_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);

  p_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> (outWord[TOP] == $past(inSign)));

  p_trunc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !inFracExt[2] && inExp != EXP_MAX) |=>
      (outWord[TOP-1:0] == $past({inExp, inFracExt[FRAC_W+2:3]})));

  p_tie_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inFracExt[2:0] == 3'b100 && inExp < SAT_EXP) |=> !outWord[0]);

  p_sat_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    outOverflow |-> (outWord[TOP-1:0] == {SAT_EXP, {FRAC_W{1'b1}}}));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> ($stable(outWord) && $stable(outOverflow)));

endmodule

bind fpRound fpRoundChk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (.*);

// File: tb/fpRound_tb.sv
module fpRound_tb;

  localparam int EXP_W  = 5;
  localparam int FRAC_W = 6;
  localparam int NVEC   = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic        inSign = 1'b0;
  logic [4:0]  inExp = '0;
  logic [8:0]  inFracExt = '0;
  logic        outValid;
  logic [11:0] outWord;
  logic        outOverflow;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  fpRound #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inSign(inSign),
    .inExp(inExp), .inFracExt(inFracExt), .outValid(outValid),
    .outWord(outWord), .outOverflow(outOverflow)
  );

  // {sign, exp, fracExt, expected word, expected overflow}
  localparam logic [27:0] VEC [NVEC] = '{
    {1'b0, 5'b10100, 9'b011011_100, 12'b0_10100_011100, 1'b0}, // R4 tie, lsb 1
    {1'b1, 5'b10010, 9'b100010_100, 12'b1_10010_100010, 1'b0}, // R4 tie, lsb 0
    {1'b0, 5'b01111, 9'b101010_011, 12'b0_01111_101010, 1'b0}, // R2 below half
    {1'b0, 5'b00011, 9'b000111_101, 12'b0_00011_001000, 1'b0}, // R3 above half
    {1'b1, 5'b01010, 9'b110000_110, 12'b1_01010_110001, 1'b0}, // R3 round bit
    {1'b0, 5'b10000, 9'b111111_111, 12'b0_10001_000000, 1'b0}, // R5 carry
    {1'b1, 5'b00001, 9'b111111_100, 12'b1_00010_000000, 1'b0}, // R5 tie carry
    {1'b0, 5'b11110, 9'b111111_110, 12'b0_11110_111111, 1'b1}, // R6 carry saturates
    {1'b1, 5'b11110, 9'b111111_100, 12'b1_11110_111111, 1'b1}, // R6 negative
    {1'b0, 5'b11110, 9'b000001_111, 12'b0_11110_000010, 1'b0}, // R6 edge, no carry
    {1'b0, 5'b11111, 9'b000000_000, 12'b0_11110_111111, 1'b1}, // R6 input all ones
    {1'b1, 5'b00101, 9'b111111_000, 12'b1_00101_111111, 1'b0}, // R2 exact
    {1'b0, 5'b00000, 9'b000000_001, 12'b0_00000_000000, 1'b0}  // R2 sticky only
  };

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  initial begin
    #100000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [11:0] lastWord;
    // R9 reset state
    repeat (3) @(posedge clk);
    #1;
    check("R9 valid", {11'b0, outValid}, 12'd0);
    check("R9 word", outWord, 12'd0);
    check("R9 ovf", {11'b0, outOverflow}, 12'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1..R8: vectors back to back, one per cycle
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      inValid   = 1'b1;
      inSign    = VEC[i][27];
      inExp     = VEC[i][26:22];
      inFracExt = VEC[i][21:13];
      @(posedge clk);
      #1;
      check($sformatf("R1 vec%0d word", i), outWord, VEC[i][12:1]);
      check($sformatf("R6 vec%0d ovf", i), {11'b0, outOverflow}, {11'b0, VEC[i][0]});
      check($sformatf("R8 vec%0d valid", i), {11'b0, outValid}, 12'd1);
      check($sformatf("R7 vec%0d sign", i), {11'b0, outWord[11]}, {11'b0, VEC[i][27]});
    end

    // R10: idle input with different operand leaves outputs alone
    lastWord = outWord;
    @(negedge clk);
    inValid   = 1'b0;
    inSign    = 1'b0;
    inExp     = 5'b11111;
    inFracExt = 9'b101010_111;
    @(posedge clk);
    #1;
    check("R8 valid drops", {11'b0, outValid}, 12'd0);
    check("R10 word held", outWord, lastWord);
    check("R10 ovf held", {11'b0, outOverflow}, 12'd0);

    // R8 latency: before the capturing edge the old value is still visible
    @(negedge clk);
    inValid   = 1'b1;
    inSign    = 1'b0;
    inExp     = 5'b01000;
    inFracExt = 9'b000000_000;
    #1;
    check("R8 not yet", outWord, lastWord);
    @(posedge clk);
    #1;
    check("R8 one cycle", outWord, 12'b0_01000_000000);

    // R9 reset in mid run clears outputs
    @(negedge clk);
    inValid = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R9 async word", outWord, 12'd0);
    check("R9 async valid", {11'b0, outValid}, 12'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule